// File: doc/BRIEF.md
# Load-Reserved Store-Conditional Monitor

This block tracks address reservations for atomic read-modify-write sequences built from a load-reserved and a later store-conditional. Several requesters share the block, and each is identified by a CPU number and a thread number. For every store presented to memory, the block decides whether the write may go ahead. It also produces a pass/fail code for conditional stores. The memory array sits beside it and uses the write-enable.

Reservations work on aligned 16-byte granules, so the low four address bits take no part in any comparison. A small table holds at most one reservation per context. When the table is full, the least recently reserved entry gives way to a new one. Every store checks the table, conditional or not, and removes every reservation on its granule. A conditional store succeeds only when its own context holds a reservation on that granule.

There is one request per cycle. Each request gets one registered response in the following cycle.

Top module: `lrsc_monitor`

## Requirements
- R1: Addresses that differ only in bits [3:0] fall in the same granule. A reservation made at one of them is matched by a store or conditional store at any other address in that granule.
- R2: A conditional store succeeds only if the reservation on its granule carries both the same CPU number and the same thread number as the request. A reservation held by another CPU or by another thread of the same CPU makes it fail.
- R3: A conditional store that finds no matching reservation, including one issued while the table is empty, returns rsp_wr_en=0 and rsp_sc_ok=0.
- R4: A plain store always returns rsp_wr_en=1 and rsp_sc_ok=0, whether or not the table holds reservations.
- R5: A plain store from any context removes every reservation on its granule, so later conditional stores to that granule fail. Reservations on other granules are kept.
- R6: A successful conditional store returns rsp_wr_en=1 and rsp_sc_ok=1. It removes every reservation on its granule, its own included, so a repeated conditional store to that granule fails.
- R7: A new load-reserved from a context that already holds a reservation replaces that reservation, so the old granule no longer succeeds for that context.
- R8: When all ENTRIES slots are valid, a load-reserved from a context with no entry evicts the least recently reserved entry. A replacement under R7 counts as the most recent reservation.
- R9: While a slot is free, a new reservation takes that slot and no existing reservation is lost.
- R10: The response is registered one cycle after the request. rsp_valid is high exactly in the cycle after req_valid. Op codes on req_op are 01 load-reserved, 10 plain store, 11 conditional store, and 00 no action. Load-reserved and no-action requests return rsp_wr_en=0 and rsp_sc_ok=0, and an idle cycle leaves all outputs low.
- R11: After reset the table is empty and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 01 reserve, 10 store, 11 conditional store, 00 none |
| req_addr | input | ADDR_W | Byte address of the request |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thr | input | THR_W | Thread number within the CPU |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_wr_en | output | 1 | The store may be written to memory |
| rsp_sc_ok | output | 1 | Conditional store succeeded (1) or failed (0) |

## Verification
The bench builds the block with ENTRIES=4, CPU_W=2, THR_W=1 and ADDR_W=16. That gives eight contexts competing for four slots, so only a handful of reservations are needed to reach eviction, age refresh on replacement, and reuse of freed slots. Directed sequences cover granule aliasing, context mismatch, and clearing by plain and conditional stores. A long mixed phase over six granules then keeps the table cycling between full and partly free states.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'b00,
    OP_RESERVE = 2'b01,
    OP_STORE   = 2'b10,
    OP_COND    = 2'b11
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_rst_sync.sv
module lrsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lrsc_match.sv
module lrsc_match #(
  parameter int ENTRIES = 8,
  parameter int GW      = 28,
  parameter int CW      = 6
) (
  input  logic [ENTRIES-1:0]    ent_valid,
  input  logic [ENTRIES*GW-1:0] ent_gran,
  input  logic [ENTRIES*CW-1:0] ent_ctx,
  input  logic [GW-1:0]         req_gran,
  input  logic [CW-1:0]         req_ctx,
  output logic [ENTRIES-1:0]    gran_hit,
  output logic [ENTRIES-1:0]    ctx_hit
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign gran_hit[i] = ent_valid[i] && (ent_gran[i*GW +: GW] == req_gran);
    assign ctx_hit[i]  = ent_valid[i] && (ent_ctx[i*CW +: CW] == req_ctx);
  end
endmodule

// File: rtl/lrsc_age_matrix.sv
module lrsc_age_matrix #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [ENTRIES-1:0] touch,
  output logic [ENTRIES-1:0] oldest
);
  localparam int BITS = ENTRIES * ENTRIES;

  // elder_q[i*ENTRIES+j] = 1 when entry i was touched before entry j
  logic [BITS-1:0] elder_q, elder_d;

  always_comb begin
    elder_d = elder_q;
    for (int i = 0; i < ENTRIES; i++) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (touch[i])      elder_d[i*ENTRIES+j] = 1'b0;
        else if (touch[j]) elder_d[i*ENTRIES+j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        elder_q <= '0;
    else if (touch_en) elder_q <= elder_d;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [ENTRIES-1:0] row;
      row    = elder_q[i*ENTRIES +: ENTRIES];
      row[i] = 1'b1;
      oldest[i] = &row;
    end
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CPU_W     = 4,
  parameter int THR_W     = 2,
  parameter int ENTRIES   = 8,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [THR_W-1:0]  req_thr,
  output logic              rsp_valid,
  output logic              rsp_wr_en,
  output logic              rsp_sc_ok
);
  localparam int GW = ADDR_W - GRAN_BITS;
  localparam int CW = CPU_W + THR_W;

  logic rst_sync_n;

  lrsc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Request decode
  logic [GW-1:0] req_gran;
  logic [CW-1:0] req_ctx;
  logic          gran_offset_unused;
  logic          is_resv, is_store, is_cond;

  assign req_gran           = req_addr[ADDR_W-1:GRAN_BITS];
  assign gran_offset_unused = ^req_addr[GRAN_BITS-1:0];
  assign req_ctx            = {req_cpu, req_thr};
  assign is_resv  = req_valid && (req_op == OP_RESERVE);
  assign is_store = req_valid && (req_op == OP_STORE);
  assign is_cond  = req_valid && (req_op == OP_COND);

  // Reservation table
  logic [ENTRIES-1:0]    ent_valid_q, ent_valid_d;
  logic [ENTRIES*GW-1:0] ent_gran_q;
  logic [ENTRIES*CW-1:0] ent_ctx_q;
  logic [ENTRIES-1:0]    gran_hit, ctx_hit;
  logic [ENTRIES-1:0]    oldest, free_slots, first_free, slot;
  logic                  cond_ok;

  lrsc_match #(.ENTRIES(ENTRIES), .GW(GW), .CW(CW)) u_match (
    .ent_valid (ent_valid_q),
    .ent_gran  (ent_gran_q),
    .ent_ctx   (ent_ctx_q),
    .req_gran  (req_gran),
    .req_ctx   (req_ctx),
    .gran_hit  (gran_hit),
    .ctx_hit   (ctx_hit)
  );

  lrsc_age_matrix #(.ENTRIES(ENTRIES)) u_age (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .touch_en (is_resv),
    .touch    (slot),
    .oldest   (oldest)
  );

  // Slot choice: own entry, else lowest free, else oldest
  always_comb begin
    free_slots = ~ent_valid_q;
    first_free = free_slots & (~free_slots + {{(ENTRIES-1){1'b0}}, 1'b1});
    if (|ctx_hit)         slot = ctx_hit;
    else if (|free_slots) slot = first_free;
    else                  slot = oldest;
  end

  assign cond_ok = is_cond && |(gran_hit & ctx_hit);

  always_comb begin
    ent_valid_d = ent_valid_q;
    if (is_store || is_cond) ent_valid_d = ent_valid_d & ~gran_hit;
    if (is_resv)             ent_valid_d = ent_valid_d | slot;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ent_valid_q <= '0;
    else             ent_valid_q <= ent_valid_d;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic load_en;
    assign load_en = is_resv && slot[i];

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        ent_gran_q[i*GW +: GW] <= '0;
        ent_ctx_q[i*CW +: CW]  <= '0;
      end else if (load_en) begin
        ent_gran_q[i*GW +: GW] <= req_gran;
        ent_ctx_q[i*CW +: CW]  <= req_ctx;
      end
    end
  end

  // Registered response
  logic rsp_valid_d, rsp_wr_en_d, rsp_sc_ok_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_wr_en_d = is_store || cond_ok;
    rsp_sc_ok_d = cond_ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_wr_en <= 1'b0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_wr_en <= rsp_wr_en_d;
      rsp_sc_ok <= rsp_sc_ok_d;
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk
  import lrsc_pkg::*;
#(
  parameter int GW    = 28,
  parameter int CPU_W = 4,
  parameter int THR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic [GW-1:0]    req_gran,
  input logic [CPU_W-1:0] req_cpu,
  input logic [THR_W-1:0] req_thr,
  input logic             rsp_valid,
  input logic             rsp_wr_en,
  input logic             rsp_sc_ok
);
  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_wr_en && !rsp_sc_ok));

  assert_reserve_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_RESERVE) |=> (!rsp_wr_en && !rsp_sc_ok));

  assert_store_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_STORE) |=> (rsp_wr_en && !rsp_sc_ok));

  assert_cond_write_tracks_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_COND) |=> (rsp_wr_en == rsp_sc_ok));

  assert_ok_implies_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_sc_ok |-> (rsp_wr_en && rsp_valid));

  assert_repeat_cond_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_COND && $past(req_valid && req_op == OP_COND) &&
     req_gran == $past(req_gran) && req_cpu == $past(req_cpu) &&
     req_thr == $past(req_thr)) |=> !rsp_sc_ok);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(
  .GW    (ADDR_W - GRAN_BITS),
  .CPU_W (CPU_W),
  .THR_W (THR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_gran  (req_addr[ADDR_W-1:GRAN_BITS]),
  .req_cpu   (req_cpu),
  .req_thr   (req_thr),
  .rsp_valid (rsp_valid),
  .rsp_wr_en (rsp_wr_en),
  .rsp_sc_ok (rsp_sc_ok)
);

// File: tb/lrsc_monitor_test.sv
module lrsc_monitor_test;
  localparam int ADDR_W = 16;
  localparam int CPU_W  = 2;
  localparam int THR_W  = 1;
  localparam int NENT   = 4;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [CPU_W-1:0]  req_cpu;
  logic [THR_W-1:0]  req_thr;
  logic              rsp_valid, rsp_wr_en, rsp_sc_ok;

  lrsc_monitor #(
    .ADDR_W(ADDR_W), .CPU_W(CPU_W), .THR_W(THR_W), .ENTRIES(NENT), .GRAN_BITS(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_cpu(req_cpu), .req_thr(req_thr),
    .rsp_valid(rsp_valid), .rsp_wr_en(rsp_wr_en), .rsp_sc_ok(rsp_sc_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit    v;
    bit    wr;
    bit    ok;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  bit m_v[NENT];
  int m_g[NENT];
  int m_c[NENT];
  int m_s[NENT];
  int stamp = 0;

  task automatic check(input bit cond, input string tag, input string msg);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) m_v[i] = 0;
  endtask

  task automatic send(input logic [1:0] op, input int addr, input int cpu,
                      input int thr, input string tag);
    exp_t e;
    int g, c, slot;
    bit ok;
    g = addr >> 4;
    c = cpu * 2 + thr;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = addr[ADDR_W-1:0];
    req_cpu   = cpu[CPU_W-1:0];
    req_thr   = thr[THR_W-1:0];
    e.v = 1; e.wr = 0; e.ok = 0; e.tag = tag;
    if (op == 2'b01) begin
      slot = -1;
      for (int i = 0; i < NENT; i++) if (m_v[i] && m_c[i] == c) slot = i;
      if (slot < 0) for (int i = NENT - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = 0;
        for (int i = 1; i < NENT; i++) if (m_s[i] < m_s[slot]) slot = i;
      end
      m_v[slot] = 1; m_g[slot] = g; m_c[slot] = c; m_s[slot] = stamp;
      stamp++;
    end else if (op == 2'b10 || op == 2'b11) begin
      ok = 0;
      for (int i = 0; i < NENT; i++) if (m_v[i] && m_g[i] == g && m_c[i] == c) ok = 1;
      for (int i = 0; i < NENT; i++) if (m_v[i] && m_g[i] == g) m_v[i] = 0;
      if (op == 2'b10) e.wr = 1;
      else begin e.wr = ok; e.ok = ok; end
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    exp_t e;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_op    = 2'b00;
      e.v = 0; e.wr = 0; e.ok = 0; e.tag = "R10";
      q.push_back(e);
    end
  endtask

  // Monitor: compares each response with the queued expectation
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.v)
          check(rsp_valid && rsp_wr_en == e.wr && rsp_sc_ok == e.ok, e.tag,
                $sformatf("valid=%0b wr=%0b ok=%0b expected valid=1 wr=%0b ok=%0b",
                          rsp_valid, rsp_wr_en, rsp_sc_ok, e.wr, e.ok));
        else
          check(!rsp_valid && !rsp_wr_en && !rsp_sc_ok, e.tag,
                $sformatf("valid=%0b wr=%0b ok=%0b expected 0 0 0",
                          rsp_valid, rsp_wr_en, rsp_sc_ok));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00;
    req_addr = '0; req_cpu = '0; req_thr = '0;
    model_reset();
    repeat (5) @(negedge clk);
    check(!rsp_valid && !rsp_wr_en && !rsp_sc_ok, "R11",
          $sformatf("in reset %0b%0b%0b expected 000", rsp_valid, rsp_wr_en, rsp_sc_ok));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rsp_valid && !rsp_wr_en && !rsp_sc_ok, "R11",
          $sformatf("after reset %0b%0b%0b expected 000", rsp_valid, rsp_wr_en, rsp_sc_ok));

    // R3 / R11: empty table, conditional store fails
    send(2'b11, 'h100, 0, 0, "R3");
    // R4: plain store writes
    send(2'b10, 'h100, 0, 0, "R4");
    // R1 / R6: granule aliasing then success, repeat fails
    send(2'b01, 'h200, 0, 0, "R10");
    idle(1);
    send(2'b11, 'h20C, 0, 0, "R1");
    send(2'b11, 'h200, 0, 0, "R6");
    // R2: wrong thread, wrong cpu, then matching context
    send(2'b01, 'h300, 0, 0, "R10");
    send(2'b11, 'h300, 0, 1, "R2");
    send(2'b01, 'h300, 0, 0, "R10");
    send(2'b11, 'h300, 1, 0, "R2");
    send(2'b01, 'h305, 0, 0, "R10");
    send(2'b11, 'h30A, 0, 0, "R2");
    // R5: store to other granule keeps, store to granule clears all
    send(2'b01, 'h400, 0, 0, "R10");
    send(2'b01, 'h408, 1, 0, "R10");
    send(2'b10, 'h500, 2, 0, "R4");
    send(2'b11, 'h404, 1, 0, "R5");
    send(2'b01, 'h400, 0, 0, "R10");
    send(2'b01, 'h400, 1, 0, "R10");
    send(2'b10, 'h40F, 3, 1, "R5");
    send(2'b11, 'h400, 0, 0, "R5");
    send(2'b11, 'h400, 1, 0, "R5");
    // R6: success clears other contexts on the granule
    send(2'b01, 'h600, 0, 0, "R10");
    send(2'b01, 'h600, 1, 1, "R10");
    send(2'b11, 'h600, 0, 0, "R6");
    send(2'b11, 'h600, 1, 1, "R6");
    // R7: replacement
    send(2'b01, 'h700, 2, 0, "R10");
    send(2'b01, 'h800, 2, 0, "R10");
    send(2'b11, 'h700, 2, 0, "R7");
    send(2'b11, 'h800, 2, 0, "R7");
    // R8 / R9: eviction, free-slot reuse, refresh on replacement
    for (int c = 0; c < 4; c++) send(2'b01, 'h1000 + c * 'h10, c, 0, "R10");
    send(2'b01, 'h1100, 0, 1, "R8");
    send(2'b11, 'h1000, 0, 0, "R8");
    send(2'b11, 'h1010, 1, 0, "R8");
    send(2'b01, 'h1110, 1, 1, "R9");
    send(2'b11, 'h1020, 2, 0, "R9");
    send(2'b01, 'h1120, 2, 1, "R10");
    send(2'b01, 'h1130, 3, 0, "R7");
    send(2'b01, 'h1140, 0, 0, "R8");
    send(2'b11, 'h1100, 0, 1, "R8");
    send(2'b11, 'h1030, 3, 0, "R7");
    send(2'b11, 'h1130, 3, 0, "R8");
    send(2'b11, 'h1110, 1, 1, "R8");
    // R10: no-action op and idle gaps
    send(2'b00, 'h1140, 0, 0, "R10");
    idle(2);
    // Mixed phase across contexts and granules
    for (int k = 0; k < 400; k++) begin
      int op, cpu, thr, a;
      op  = $urandom_range(0, 9);
      cpu = $urandom_range(0, 3);
      thr = $urandom_range(0, 1);
      a   = 'h2000 + $urandom_range(0, 5) * 'h10 + $urandom_range(0, 15);
      if (op < 5)      send(2'b01, a, cpu, thr, "R8");
      else if (op < 6) send(2'b10, a, cpu, thr, "R5");
      else if (op < 9) send(2'b11, a, cpu, thr, "R2");
      else             idle(1);
    end
    idle(3);
    while (q.size() > 0) @(posedge clk);
    #5;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule